// File: doc/BRIEF.md
# Quad Supervisory Reset Output Controller

This block turns four digitized supply-comparator levels, a manual reset request and a watchdog expiry pulse into four independent active-low reset outputs. Each channel owns a trigger enable and a sensing polarity. The polarity decides whether a low comparator level (under-voltage) or a high comparator level (over-voltage) counts as a fault. When a source becomes active, the matching reset output goes low. It stays low for a programmable number of timebase ticks after the last source has gone away. Every channel has its own stretch counter, so the channels release independently.

Two sources are wired to all four channels and no configuration bit can mask them: the manual reset input and the watchdog expiry pulse. A per-channel status vector shows which comparator inputs are out of limit at the moment. It follows the input and does not latch. A 1 ms tick input counts the stretch time, and a 2-bit code selects 25, 50, 100 or 200 ticks. Comparator levels arrive already synchronized to the clock. A reset output of 1 means the open-drain driver has released the line, and 0 means it is pulling the line low.

Top module: `qsup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, every `rst_out_n` bit reads 0 and every `fault_stat` bit reads 0. After `rst_n` rises with no active source, the outputs release only after the selected hold time has elapsed.
- R2: With `mr_n` low, all four `rst_out_n` bits read 0 one clock later, whatever the values of `trig_en` and `pol_ov`. They stay 0 for as long as `mr_n` is low. After `mr_n` rises they stay 0 for the hold time.
- R3: A single-cycle pulse on `wdt_expire` drives all four `rst_out_n` bits to 0 on the next clock. The bits release after the hold time.
- R4: A comparator fault on channel n pulls `rst_out_n[n]` low only when `trig_en[n]` is 1. With `trig_en[n]` at 0, `rst_out_n[n]` stays 1. A fault on channel n never affects any other channel's output.
- R5: With `pol_ov[n]` = 0 (UV sensing), channel n is faulted when `cmp_level[n]` is 0. With `pol_ov[n]` = 1 (OV sensing), channel n is faulted when `cmp_level[n]` is 1.
- R6: Once every source of channel n has cleared, `rst_out_n[n]` stays 0 for exactly N accepted ticks. It reads 1 after the clock edge that accepts the Nth tick.
- R7: `hold_sel` sets N as follows: 2'b00 gives 25 ticks, 2'b01 gives 50, 2'b10 gives 100 and 2'b11 gives 200.
- R8: If a source reasserts during the stretch, the partial count is discarded. The full N ticks start over from zero when that source clears again.
- R9: `fault_stat[n]` equals the channel n fault condition of R5, registered by one clock, whatever the value of `trig_en[n]`. It returns to 0 when the input comes back within limit.
- R10: An output is asserted on the clock after its source becomes active. Ticks that arrive while a source is still active never release that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | Single-cycle timebase strobe, one per millisecond |
| cmp_level | input | NUM_CH | Synchronized comparator levels, 1 = above threshold |
| mr_n | input | 1 | Manual reset request, active low |
| wdt_expire | input | 1 | Watchdog expiry pulse, active high |
| trig_en | input | NUM_CH | Per-channel voltage trigger enable |
| pol_ov | input | NUM_CH | Per-channel sensing polarity, 0 = UV, 1 = OV |
| hold_sel | input | 2 | Reset hold time code |
| rst_out_n | output | NUM_CH | Active-low reset outputs, 1 = released |
| fault_stat | output | NUM_CH | Live per-channel out-of-limit flags |

## Verification
The bound checker watches the following properties on every cycle. An active source on a channel forces that output low on the next clock. Manual reset and watchdog expiry force all four outputs low. An output only rises on the edge that accepts a tick. The status vector tracks the registered fault condition. Bench scenarios are the only way to show the exact tick count of each hold code, the count restarting after a mid-stretch reassertion, the disabled channel staying released, and the independence between channels.

// File: rtl/qsup_pkg.sv
// Shared helpers for the quad supervisory reset controller.
// Assumes the hold code doubles the base tick count for each step.
package qsup_pkg;

    // Number of timebase ticks that a given hold code selects.
    function automatic int unsigned hold_ticks(input logic [1:0] code,
                                               input int unsigned base);
        return base << code;
    endfunction

endpackage

// File: rtl/qsup_fault_detect.sv
// Per-channel out-of-limit decode.
// Assumes comparator levels are already synchronized; 1 means above threshold.
module qsup_fault_detect #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] cmp_level,
    input  logic [NUM_CH-1:0] pol_ov,
    output logic [NUM_CH-1:0] fault
);

    // OV channels fault on a high level and UV channels fault on a low level.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            fault[i] = pol_ov[i] ? cmp_level[i] : ~cmp_level[i];
        end
    end

endmodule

// File: rtl/qsup_stretch_chan.sv
// One channel's reset stretcher. It holds the channel active while its
// source is present, then for LIMIT ticks afterwards.
// Assumes limit is nonzero and tick is a single-cycle strobe.
module qsup_stretch_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             src,
    input  logic [CNT_W-1:0] limit,
    output logic             active
);

    logic [CNT_W-1:0] cnt;

    // Source sets and clears the count; ticks advance it until the limit releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (src) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick) begin
            if (cnt >= limit - CNT_W'(1)) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/qsup_reset_ctrl.sv
// Quad supervisory reset controller top.
// It combines manual reset, watchdog expiry and gated voltage faults into
// one source per channel, then stretches each channel independently.
// Outputs model open-drain drivers: 0 pulls low, 1 means released.
module qsup_reset_ctrl #(
    parameter int NUM_CH     = 4,
    parameter int BASE_TICKS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic [NUM_CH-1:0] cmp_level,
    input  logic              mr_n,
    input  logic              wdt_expire,
    input  logic [NUM_CH-1:0] trig_en,
    input  logic [NUM_CH-1:0] pol_ov,
    input  logic [1:0]        hold_sel,
    output logic [NUM_CH-1:0] rst_out_n,
    output logic [NUM_CH-1:0] fault_stat
);

    localparam int HOLD_MAX = BASE_TICKS * 8;
    localparam int CNT_W    = $clog2(HOLD_MAX + 1);

    logic [NUM_CH-1:0] fault;
    logic [NUM_CH-1:0] src;
    logic [NUM_CH-1:0] active;
    logic [CNT_W-1:0]  hold_limit;

    qsup_fault_detect #(.NUM_CH(NUM_CH)) u_detect (
        .cmp_level (cmp_level),
        .pol_ov    (pol_ov),
        .fault     (fault)
    );

    // Hold length in ticks for the selected code.
    always_comb begin
        hold_limit = CNT_W'(qsup_pkg::hold_ticks(hold_sel, BASE_TICKS));
    end

    // Hardwired sources reach every channel; voltage faults pass only when enabled.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            src[i] = ~mr_n | wdt_expire | (trig_en[i] & fault[i]);
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
            qsup_stretch_chan #(.CNT_W(CNT_W)) u_stretch (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick_1ms),
                .src    (src[g]),
                .limit  (hold_limit),
                .active (active[g])
            );
        end
    endgenerate

    // Volatile status: register the live fault condition, ignoring enables.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_stat <= '0;
        else        fault_stat <= fault;
    end

    // Drive low while a channel is active, release otherwise.
    always_comb begin
        rst_out_n = ~active;
    end

endmodule

// File: rtl/qsup_reset_ctrl_chk.sv
// Cycle-level checker for qsup_reset_ctrl, attached through bind.
// It recomputes the per-channel sources from the ports only.
module qsup_reset_ctrl_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1ms,
    input logic [NUM_CH-1:0] cmp_level,
    input logic              mr_n,
    input logic              wdt_expire,
    input logic [NUM_CH-1:0] trig_en,
    input logic [NUM_CH-1:0] pol_ov,
    input logic [NUM_CH-1:0] rst_out_n,
    input logic [NUM_CH-1:0] fault_stat
);

    logic [NUM_CH-1:0] chk_fault;
    logic [NUM_CH-1:0] chk_src;

    // Port-level view of each channel's fault and source.
    always_comb begin
        chk_fault = (cmp_level & pol_ov) | (~cmp_level & ~pol_ov);
        chk_src   = {NUM_CH{~mr_n | wdt_expire}} | (trig_en & chk_fault);
    end

    assert_mr_all_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_n |=> (rst_out_n == '0));

    assert_wdt_all_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expire |=> (rst_out_n == '0));

    assert_src_asserts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_src != '0) |=> ((rst_out_n & $past(chk_src)) == '0));

    assert_release_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_out_n & ~$past(rst_out_n)) != '0) |-> $past(tick_1ms));

    assert_status_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fault_stat == $past(chk_fault)));

endmodule

bind qsup_reset_ctrl qsup_reset_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1ms   (tick_1ms),
    .cmp_level  (cmp_level),
    .mr_n       (mr_n),
    .wdt_expire (wdt_expire),
    .trig_en    (trig_en),
    .pol_ov     (pol_ov),
    .rst_out_n  (rst_out_n),
    .fault_stat (fault_stat)
);

// File: tb/test_qsup_reset_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected output snapshots into a queue,
// and the monitor pops and compares them on the falling edge.
module test_qsup_reset_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_1ms;
    logic [3:0] cmp_level;
    logic       mr_n;
    logic       wdt_expire;
    logic [3:0] trig_en;
    logic [3:0] pol_ov;
    logic [1:0] hold_sel;
    logic [3:0] rst_out_n;
    logic [3:0] fault_stat;

    typedef struct {
        logic [3:0] rst;
        logic [3:0] stat;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #2.5 clk = ~clk;

    qsup_reset_ctrl i_qsup_reset_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_1ms   (tick_1ms),
        .cmp_level  (cmp_level),
        .mr_n       (mr_n),
        .wdt_expire (wdt_expire),
        .trig_en    (trig_en),
        .pol_ov     (pol_ov),
        .hold_sel   (hold_sel),
        .rst_out_n  (rst_out_n),
        .fault_stat (fault_stat)
    );

    // Hold length from the code table of R7.
    function automatic int hold_of(input logic [1:0] code);
        case (code)
            2'b00:   return 25;
            2'b01:   return 50;
            2'b10:   return 100;
            default: return 200;
        endcase
    endfunction

    // Let one clock edge pass, then queue the expected outputs for the next falling edge.
    task automatic expect_now(input logic [3:0] r, input logic [3:0] s, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.rst = r; e.stat = s; e.tag = tag;
        q.push_back(e);
    endtask

    // Issue n single-cycle timebase ticks.
    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick_1ms = 1'b1;
            @(negedge clk) tick_1ms = 1'b0;
        end
    endtask

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rst_out_n !== e.rst || fault_stat !== e.stat) begin
                errors++;
                $display("FAIL %s: rst_out_n=%b fault_stat=%b expected rst_out_n=%b fault_stat=%b",
                         e.tag, rst_out_n, fault_stat, e.rst, e.stat);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver: stimulus and expected values per requirement.
    initial begin
        rst_n = 1'b0; tick_1ms = 1'b0; cmp_level = 4'hF; mr_n = 1'b1;
        wdt_expire = 1'b0; trig_en = 4'h0; pol_ov = 4'h0; hold_sel = 2'b00;
        repeat (3) @(posedge clk);
        expect_now(4'h0, 4'h0, "R1 reset state");

        // R1, R6: power-up hold of 25 ticks
        @(negedge clk) rst_n = 1'b1;
        pulse_ticks(hold_of(2'b00) - 1);
        expect_now(4'h0, 4'h0, "R1 R6 still held one tick short");
        pulse_ticks(1);
        expect_now(4'hF, 4'h0, "R1 R7 released after 25 ticks");

        // R4, R5, R9: channel 0 UV fault
        @(negedge clk) begin trig_en = 4'b1101; cmp_level[0] = 1'b0; end
        expect_now(4'b1110, 4'b0001, "R4 R5 R9 ch0 UV fault");

        // R6, R7: 50-tick hold; R9 status clears at once
        @(negedge clk) begin cmp_level[0] = 1'b1; hold_sel = 2'b01; end
        expect_now(4'b1110, 4'b0000, "R9 status volatile R6 held");
        pulse_ticks(hold_of(2'b01) - 1);
        expect_now(4'b1110, 4'b0000, "R6 ch0 held 49 ticks");
        pulse_ticks(1);
        expect_now(4'hF, 4'h0, "R7 ch0 released after 50 ticks");

        // R4: disabled channel 1 is ignored at its output, R9 still reports it
        @(negedge clk) cmp_level[1] = 1'b0;
        expect_now(4'hF, 4'b0010, "R4 disabled ch1 stays released R9");
        pulse_ticks(3);
        expect_now(4'hF, 4'b0010, "R4 disabled ch1 still released");
        @(negedge clk) cmp_level[1] = 1'b1;
        expect_now(4'hF, 4'h0, "R9 ch1 status cleared");

        // R5: channel 2 OV sensing
        @(negedge clk) begin pol_ov = 4'b0100; cmp_level[2] = 1'b0; end
        expect_now(4'hF, 4'h0, "R5 OV low level is no fault");
        @(negedge clk) cmp_level[2] = 1'b1;
        expect_now(4'b1011, 4'b0100, "R5 OV high level faults ch2");
        @(negedge clk) begin cmp_level[2] = 1'b0; hold_sel = 2'b10; end
        pulse_ticks(hold_of(2'b10) - 1);
        expect_now(4'b1011, 4'h0, "R6 ch2 held 99 ticks");
        pulse_ticks(1);
        expect_now(4'hF, 4'h0, "R7 ch2 released after 100 ticks");

        // R8, R10: restart on reassertion, channel 3 UV
        @(negedge clk) begin hold_sel = 2'b00; cmp_level[3] = 1'b0; end
        expect_now(4'b0111, 4'b1000, "R4 ch3 UV fault");
        @(negedge clk) cmp_level[3] = 1'b1;
        pulse_ticks(10);
        expect_now(4'b0111, 4'h0, "R6 ch3 mid-stretch");
        @(negedge clk) cmp_level[3] = 1'b0;
        pulse_ticks(30);
        expect_now(4'b0111, 4'b1000, "R10 ticks during active source do not release");
        @(negedge clk) cmp_level[3] = 1'b1;
        pulse_ticks(hold_of(2'b00) - 1);
        expect_now(4'b0111, 4'h0, "R8 count restarted, 24 ticks still held");
        pulse_ticks(1);
        expect_now(4'hF, 4'h0, "R8 released after full 25 ticks");

        // R2: manual reset with every enable cleared
        @(negedge clk) begin trig_en = 4'h0; mr_n = 1'b0; end
        expect_now(4'h0, 4'h0, "R2 manual reset forces all low");
        pulse_ticks(30);
        expect_now(4'h0, 4'h0, "R2 held while manual reset low");
        @(negedge clk) begin mr_n = 1'b1; hold_sel = 2'b11; end
        pulse_ticks(hold_of(2'b11) - 1);
        expect_now(4'h0, 4'h0, "R2 held 199 ticks after release");
        pulse_ticks(1);
        expect_now(4'hF, 4'h0, "R7 released after 200 ticks");

        // R3: single-cycle watchdog pulse
        @(negedge clk) begin hold_sel = 2'b00; wdt_expire = 1'b1; end
        expect_now(4'h0, 4'h0, "R3 watchdog forces all low");
        @(negedge clk) wdt_expire = 1'b0;
        pulse_ticks(hold_of(2'b00) - 1);
        expect_now(4'h0, 4'h0, "R3 held 24 ticks after pulse");
        pulse_ticks(1);
        expect_now(4'hF, 4'h0, "R3 released after 25 ticks");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule